// File: doc/BRIEF.md
# Shared-Bus Flash and Pseudo-SRAM Access Controller

This block sits on the host side of a stacked memory package that holds a NOR flash die and a pseudo-SRAM die behind one 16-bit multiplexed address/data bus. It takes single-word requests from a valid/ready host port and turns each one into an asynchronous bus cycle. In that cycle the address is presented while the latch strobe is low. The same lines then carry write data or are released so the die can return read data. The controller drives separate chip, output and write enables per die, the upper address lines, the RAM byte-lane enables and the RAM register-select line. The burst clock is held low.

Besides plain array accesses, the host can read or write the RAM's configuration registers and can move the RAM into and out of deep power-down. A one-bit shadow of the refresh-register power-down bit guards entry. While the RAM is powered down, only flash traffic is served. Every request ends with exactly one response cycle carrying read data and an error bit. Bus timing (latch width, read and write pulse lengths, power-down exit hold) is given in controller clock cycles by parameters.

Top module: `duo_bus_ctrl`

## Requirements
- R1: The flash and RAM chip enables are never low in the same cycle. Every access is followed by at least one cycle with both chip enables high and the bus released, before any other access starts.
- R2: An accepted flash or RAM array or register request starts on the next cycle with an address phase of T_ADV cycles. In it the selected chip enable falls, the latch strobe is low, and the bus drives the low 16 bits of the address.
- R3: A read then holds the die's output enable low for T_RD cycles with the bus released. The controller captures the bus in the last of those cycles and returns the value in the response.
- R4: A write then holds the die's write enable low for T_WR cycles while the bus drives the write data. The output enables stay high.
- R5: For flash accesses, upper address lines 22:16 carry address bits 22:16. For RAM array accesses (default narrow variant), lines 20:16 carry the address and lines 22:21 are driven 0.
- R6: A RAM array access drives the upper lane enable as the inverse of byte-enable bit 1 and the lower lane enable as the inverse of bit 0. Read data on a disabled lane is returned as 0, and with both lanes off the RAM chip enable still goes low. Flash accesses keep both lane enables high.
- R7: A configuration access (op 1) raises the register-select line for its whole address and data phases. Address bits 1:0 of the request choose the register: 0 refresh, 1 bus configuration, 2 device ID. Upper line 19 is driven 1 for the bus register and 0 otherwise. For a write, the value travels on the low 16 bus bits in the address phase. Selecting the device ID in the narrow variant, or writing it, is rejected.
- R8: The burst clock output is low at all times.
- R9: A power-down entry request (op 2) is rejected unless the last value written to the refresh register had bit 4 equal to 0. After reset the controller treats that bit as 1.
- R10: An accepted entry pulls the RAM chip enable low for one cycle and raises it, then responds. While powered down, RAM array and register requests are rejected, the RAM chip enable stays high, and flash requests proceed normally.
- R11: A power-down exit request (op 3) holds the RAM chip enable low for T_DPD cycles and then responds, after which RAM accesses are served. An exit request while not powered down, or an entry while already powered down, is rejected.
- R12: Ready is high only while idle. Each request yields exactly one response cycle. A rejected request responds with the error bit set in the cycle after acceptance, and no chip enable moves.
- R13: After reset all enables and the latch strobe are high, the bus is released, ready is high and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 2 | 0 array, 1 configuration register, 2 power-down entry, 3 power-down exit |
| req_write | input | 1 | 1 for write, 0 for read |
| req_ram | input | 1 | Array target: 1 RAM, 0 flash |
| req_addr | input | 23 | Word address; bits 1:0 pick the register for op 1 |
| req_wdata | input | 16 | Write data or register value |
| req_be | input | 2 | Byte enables, bit 1 upper lane |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 16 | Read data, 0 for writes and rejections |
| bus_out | output | 16 | Value driven on the multiplexed bus |
| bus_oe | output | 1 | Bus drive enable |
| bus_in | input | 16 | Value seen on the multiplexed bus |
| addr_hi | output | 7 | Upper address lines 22:16 |
| lat_n | output | 1 | Address latch strobe, active low |
| bclk | output | 1 | Burst clock, held low |
| f_ce_n | output | 1 | Flash chip enable |
| f_oe_n | output | 1 | Flash output enable |
| f_we_n | output | 1 | Flash write enable |
| r_ce_n | output | 1 | RAM chip enable |
| r_oe_n | output | 1 | RAM output enable |
| r_we_n | output | 1 | RAM write enable |
| r_ub_n | output | 1 | RAM upper lane enable |
| r_lb_n | output | 1 | RAM lower lane enable |
| r_cre | output | 1 | RAM register select |

## Verification
A wrong sequencer state shows at the pins in the same cycle. The phase lengths change, a chip enable or strobe sits at the wrong level, or a response appears early or late, and the bench compares each pin against its own phase count every clock. A corrupted power-down flag or refresh-bit shadow stays hidden until the next power-down or RAM request. That request then returns the wrong error bit and shows an unexpected (or missing) RAM chip-enable pulse within one cycle of acceptance.

// File: rtl/duo_bus_pkg.sv
// Shared types for the dual-die bus controller.
// Assumes: request operation codes are fixed host encodings.
package duo_bus_pkg;

    typedef enum logic [1:0] {
        OP_MEM      = 2'd0,
        OP_CFG      = 2'd1,
        OP_PD_ENTER = 2'd2,
        OP_PD_EXIT  = 2'd3
    } duo_op_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADR  = 3'd1,
        ST_DAT  = 3'd2,
        ST_FIN  = 3'd3,
        ST_ERR  = 3'd4,
        ST_PDE  = 3'd5,
        ST_PDX  = 3'd6
    } duo_st_e;

    localparam logic [1:0] SEL_REFRESH = 2'd0;
    localparam logic [1:0] SEL_BUSCFG  = 2'd1;
    localparam logic [1:0] SEL_DEVID   = 2'd2;

    typedef struct packed {
        duo_op_e     op;
        logic        write;
        logic        tgt_ram;
        logic [22:0] addr;
        logic [15:0] wdata;
        logic [1:0]  be;
    } duo_req_t;

endpackage

// File: rtl/duo_seq.sv
// Access sequencer: accepts host requests, screens them against the
// power-down state and the refresh-bit shadow, and walks the address,
// data, power-down and response phases with one cycle counter.
// Assumes: timing parameters are at least 1.
module duo_seq
    import duo_bus_pkg::*;
#(
    parameter int T_ADV    = 2,
    parameter int T_RD     = 3,
    parameter int T_WR     = 2,
    parameter int T_DPD    = 8,
    parameter bit RAM_WIDE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  duo_req_t    req_in,
    input  logic [15:0] bus_in,
    output logic        req_ready,
    output duo_st_e     st,
    output duo_req_t    cur,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [15:0] rsp_rdata,
    output logic        pd_active
);

    localparam int M1   = (T_ADV > T_RD) ? T_ADV : T_RD;
    localparam int M2   = (T_WR > T_DPD) ? T_WR : T_DPD;
    localparam int CMAX = (M1 > M2) ? M1 : M2;
    localparam int CW   = ($clog2(CMAX) < 1) ? 1 : $clog2(CMAX);

    logic [CW-1:0] cnt;
    logic          shadow_b4;
    logic [15:0]   rdata_q;

    // Decide whether a request must be refused without bus activity.
    function automatic logic reject(input duo_req_t r, input logic pd, input logic sh);
        logic bad;
        case (r.op)
            OP_MEM:      bad = r.tgt_ram && pd;
            OP_CFG:      bad = pd || (r.addr[1:0] == 2'd3) ||
                               ((r.addr[1:0] == SEL_DEVID) && (!RAM_WIDE || r.write));
            OP_PD_ENTER: bad = pd || sh;
            default:     bad = !pd;
        endcase
        return bad;
    endfunction

    // Zero the read lanes a RAM array access did not enable.
    function automatic logic [15:0] lane_mask(input duo_req_t r, input logic [15:0] d);
        logic [15:0] m;
        m = d;
        if (r.op == OP_MEM && r.tgt_ram) begin
            if (!r.be[1]) m[15:8] = 8'h00;
            if (!r.be[0]) m[7:0]  = 8'h00;
        end
        return m;
    endfunction

    // Phase state machine, counter, power-down flag and shadow bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            cur       <= '0;
            shadow_b4 <= 1'b1;
            pd_active <= 1'b0;
            rdata_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    cur     <= req_in;
                    rdata_q <= '0;
                    if (reject(req_in, pd_active, shadow_b4)) begin
                        st <= ST_ERR;
                    end else begin
                        case (req_in.op)
                            OP_PD_ENTER: st <= ST_PDE;
                            OP_PD_EXIT: begin
                                st  <= ST_PDX;
                                cnt <= CW'(T_DPD - 1);
                            end
                            default: begin
                                st  <= ST_ADR;
                                cnt <= CW'(T_ADV - 1);
                            end
                        endcase
                        if (req_in.op == OP_CFG && req_in.write &&
                            req_in.addr[1:0] == SEL_REFRESH)
                            shadow_b4 <= req_in.wdata[4];
                    end
                end
                ST_ADR: begin
                    if (cnt == '0) begin
                        st  <= ST_DAT;
                        cnt <= cur.write ? CW'(T_WR - 1) : CW'(T_RD - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_DAT: begin
                    if (cnt == '0) begin
                        st <= ST_FIN;
                        if (!cur.write) rdata_q <= lane_mask(cur, bus_in);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_PDE: begin
                    pd_active <= 1'b1;
                    st        <= ST_FIN;
                end
                ST_PDX: begin
                    if (cnt == '0) begin
                        pd_active <= 1'b0;
                        st        <= ST_FIN;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Host handshake and response outputs.
    always_comb begin
        req_ready = (st == ST_IDLE);
        rsp_valid = (st == ST_FIN) || (st == ST_ERR);
        rsp_err   = (st == ST_ERR);
        rsp_rdata = rsp_valid ? rdata_q : 16'h0000;
    end

    p_rsp_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_pd_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_in.op == OP_PD_ENTER && shadow_b4) |=> rsp_err);

    p_pd_ram_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && pd_active && req_in.op == OP_MEM && req_in.tgt_ram)
        |=> rsp_err);

    p_pd_exit_path_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_active) |-> ($past(st) == ST_PDX));

endmodule

// File: rtl/duo_addr_route.sv
// Address and lane router: builds the low bus word, the upper address
// lines, the byte-lane enables and the die-select flags of the access
// held by the sequencer.
// Assumes: RAM_WIDE=0 shares lines 20:16, RAM_WIDE=1 shares 21:16.
module duo_addr_route
    import duo_bus_pkg::*;
#(
    parameter bit RAM_WIDE = 1'b0
) (
    input  duo_req_t    cur,
    output logic [15:0] lo16,
    output logic [6:0]  hi7,
    output logic [15:0] data16,
    output logic [1:0]  lanes_n,
    output logic        ram_sel,
    output logic        flash_sel,
    output logic        cfg_sel,
    output logic        is_wr
);

    localparam logic [6:0] RAM_HI_MASK = RAM_WIDE ? 7'h3F : 7'h1F;

    // Per-operation address, data and lane decode.
    always_comb begin
        lo16      = 16'h0000;
        hi7       = 7'h00;
        data16    = cur.wdata;
        lanes_n   = 2'b11;
        cfg_sel   = (cur.op == OP_CFG);
        ram_sel   = cfg_sel || (cur.op == OP_MEM && cur.tgt_ram);
        flash_sel = (cur.op == OP_MEM) && !cur.tgt_ram;
        is_wr     = cur.write;
        case (cur.op)
            OP_MEM: begin
                lo16 = cur.addr[15:0];
                if (cur.tgt_ram) begin
                    hi7     = cur.addr[22:16] & RAM_HI_MASK;
                    lanes_n = ~cur.be;
                end else begin
                    hi7 = cur.addr[22:16];
                end
            end
            OP_CFG: begin
                lo16    = cur.write ? cur.wdata : 16'h0000;
                lanes_n = 2'b00;
                hi7[3]  = (cur.addr[1:0] == SEL_BUSCFG);
                if (RAM_WIDE) hi7[2] = (cur.addr[1:0] == SEL_DEVID);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/duo_pins.sv
// Pin driver: maps the sequencer phase and the routed access onto the
// per-die enables, the latch strobe, the bus drive and the burst clock.
// Assumes: outputs are decoded from registered state only.
module duo_pins
    import duo_bus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  duo_st_e     st,
    input  logic [15:0] lo16,
    input  logic [6:0]  hi7,
    input  logic [15:0] data16,
    input  logic [1:0]  lanes_n,
    input  logic        ram_sel,
    input  logic        flash_sel,
    input  logic        cfg_sel,
    input  logic        is_wr,
    output logic [15:0] bus_out,
    output logic        bus_oe,
    output logic [6:0]  addr_hi,
    output logic        lat_n,
    output logic        bclk,
    output logic        f_ce_n,
    output logic        f_oe_n,
    output logic        f_we_n,
    output logic        r_ce_n,
    output logic        r_oe_n,
    output logic        r_we_n,
    output logic        r_ub_n,
    output logic        r_lb_n,
    output logic        r_cre
);

    logic active, adr, rd_ph, wr_ph;

    // Phase flags shared by all pins.
    always_comb begin
        adr    = (st == ST_ADR);
        active = adr || (st == ST_DAT);
        rd_ph  = (st == ST_DAT) && !is_wr;
        wr_ph  = (st == ST_DAT) && is_wr;
    end

    // Enables, strobes and bus drive per die.
    always_comb begin
        f_ce_n  = !(active && flash_sel);
        r_ce_n  = !((active && ram_sel) || st == ST_PDE || st == ST_PDX);
        f_oe_n  = !(rd_ph && flash_sel);
        r_oe_n  = !(rd_ph && ram_sel);
        f_we_n  = !(wr_ph && flash_sel);
        r_we_n  = !(wr_ph && ram_sel);
        lat_n   = !adr;
        bus_oe  = adr || wr_ph;
        bus_out = adr ? lo16 : (wr_ph ? data16 : 16'h0000);
        addr_hi = active ? hi7 : 7'h00;
        r_cre   = active && cfg_sel;
        r_ub_n  = (active && ram_sel) ? lanes_n[1] : 1'b1;
        r_lb_n  = (active && ram_sel) ? lanes_n[0] : 1'b1;
        bclk    = 1'b0;
    end

    p_oe_we_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !((!f_oe_n || !r_oe_n) && (!f_we_n || !r_we_n)));

    p_rd_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!f_oe_n || !r_oe_n) |-> !bus_oe);

    p_cre_ram_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_cre |-> (f_ce_n && !r_ce_n));

endmodule

// File: rtl/duo_bus_ctrl.sv
// Top of the dual-die multiplexed bus controller: bundles the host
// request, runs the sequencer, routes the address and drives the pins.
// Assumes: a single outstanding request; asynchronous bus mode only.
module duo_bus_ctrl
    import duo_bus_pkg::*;
#(
    parameter int T_ADV    = 2,
    parameter int T_RD     = 3,
    parameter int T_WR     = 2,
    parameter int T_DPD    = 8,
    parameter bit RAM_WIDE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_op,
    input  logic        req_write,
    input  logic        req_ram,
    input  logic [22:0] req_addr,
    input  logic [15:0] req_wdata,
    input  logic [1:0]  req_be,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [15:0] rsp_rdata,
    output logic [15:0] bus_out,
    output logic        bus_oe,
    input  logic [15:0] bus_in,
    output logic [6:0]  addr_hi,
    output logic        lat_n,
    output logic        bclk,
    output logic        f_ce_n,
    output logic        f_oe_n,
    output logic        f_we_n,
    output logic        r_ce_n,
    output logic        r_oe_n,
    output logic        r_we_n,
    output logic        r_ub_n,
    output logic        r_lb_n,
    output logic        r_cre
);

    duo_req_t    req_b, cur;
    duo_st_e     st;
    logic        pd_active;
    logic [15:0] lo16, data16;
    logic [6:0]  hi7;
    logic [1:0]  lanes_n;
    logic        ram_sel, flash_sel, cfg_sel, is_wr;

    // Pack the host fields into one request word.
    always_comb begin
        req_b.op      = duo_op_e'(req_op);
        req_b.write   = req_write;
        req_b.tgt_ram = req_ram;
        req_b.addr    = req_addr;
        req_b.wdata   = req_wdata;
        req_b.be      = req_be;
    end

    duo_seq #(
        .T_ADV(T_ADV), .T_RD(T_RD), .T_WR(T_WR), .T_DPD(T_DPD), .RAM_WIDE(RAM_WIDE)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_in(req_b),
        .bus_in(bus_in), .req_ready(req_ready), .st(st), .cur(cur),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .pd_active(pd_active)
    );

    duo_addr_route #(.RAM_WIDE(RAM_WIDE)) i_route (
        .cur(cur), .lo16(lo16), .hi7(hi7), .data16(data16), .lanes_n(lanes_n),
        .ram_sel(ram_sel), .flash_sel(flash_sel), .cfg_sel(cfg_sel), .is_wr(is_wr)
    );

    duo_pins i_pins (
        .clk(clk), .rst_n(rst_n), .st(st), .lo16(lo16), .hi7(hi7), .data16(data16),
        .lanes_n(lanes_n), .ram_sel(ram_sel), .flash_sel(flash_sel),
        .cfg_sel(cfg_sel), .is_wr(is_wr), .bus_out(bus_out), .bus_oe(bus_oe),
        .addr_hi(addr_hi), .lat_n(lat_n), .bclk(bclk), .f_ce_n(f_ce_n),
        .f_oe_n(f_oe_n), .f_we_n(f_we_n), .r_ce_n(r_ce_n), .r_oe_n(r_oe_n),
        .r_we_n(r_we_n), .r_ub_n(r_ub_n), .r_lb_n(r_lb_n), .r_cre(r_cre)
    );

    p_ce_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        f_ce_n || r_ce_n);

    p_gap_flash_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(f_ce_n) |-> ($past(r_ce_n) && $past(f_ce_n)));

    p_gap_ram_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_ce_n) |-> ($past(f_ce_n) && $past(r_ce_n)));

    p_pd_no_ram_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && st != ST_PDX) |-> r_ce_n);

endmodule

// File: tb/test_duo_bus_ctrl.sv
module test_duo_bus_ctrl;

    localparam int T_ADV = 2;
    localparam int T_RD  = 3;
    localparam int T_WR  = 2;
    localparam int T_DPD = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic        req_write = 1'b0;
    logic        req_ram = 1'b0;
    logic [22:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        rsp_valid, rsp_err;
    logic [15:0] rsp_rdata, bus_out, bus_in;
    logic        bus_oe;
    logic [6:0]  addr_hi;
    logic        lat_n, bclk, f_ce_n, f_oe_n, f_we_n, r_ce_n, r_oe_n, r_we_n;
    logic        r_ub_n, r_lb_n, r_cre;
    logic [15:0] dev_word = 16'h0000;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // Die model: drives the word while either output enable is low.
    assign bus_in = (!f_oe_n || !r_oe_n) ? dev_word : 16'h0000;

    duo_bus_ctrl #(.T_ADV(T_ADV), .T_RD(T_RD), .T_WR(T_WR), .T_DPD(T_DPD)) i_duo_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_write(req_write), .req_ram(req_ram), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
        .addr_hi(addr_hi), .lat_n(lat_n), .bclk(bclk), .f_ce_n(f_ce_n), .f_oe_n(f_oe_n),
        .f_we_n(f_we_n), .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n),
        .r_ub_n(r_ub_n), .r_lb_n(r_lb_n), .r_cre(r_cre)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Every-clock invariants: exclusive enables (R1), burst clock low (R8).
    always @(negedge clk) if (rst_n && !done) begin
        chk("R1", "both chip enables low", {31'd0, f_ce_n || r_ce_n}, 32'd1);
        chk("R8", "burst clock", {31'd0, bclk}, 32'd0);
    end

    task automatic idle_pins(input string rq);
        chk(rq, "f_ce_n idle", {31'd0, f_ce_n}, 1);
        chk(rq, "r_ce_n idle", {31'd0, r_ce_n}, 1);
        chk(rq, "lat_n idle", {31'd0, lat_n}, 1);
        chk(rq, "oe/we idle", {28'd0, f_oe_n, f_we_n, r_oe_n, r_we_n}, 32'hF);
        chk(rq, "bus_oe idle", {31'd0, bus_oe}, 0);
        chk(rq, "ready idle", {31'd0, req_ready}, 1);
        chk(rq, "rsp idle", {31'd0, rsp_valid}, 0);
    endtask

    // One request with cycle-by-cycle expectations from the phase count.
    task automatic access(input string rq, input logic [1:0] op, input logic wr,
                          input logic ram, input logic [22:0] a, input logic [15:0] wd,
                          input logic [1:0] be, input logic eerr, input logic [6:0] ehi,
                          input logic [15:0] elo, input logic [15:0] erd,
                          input logic [1:0] elanes);
        int nd, len;
        logic ramish, cfg;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_write = wr; req_ram = ram;
        req_addr = a; req_wdata = wd; req_be = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cfg    = (op == 2'd1);
        ramish = cfg || ram;
        nd     = wr ? T_WR : T_RD;
        if (eerr)            len = 1;
        else if (op == 2'd2) len = 2;
        else if (op == 2'd3) len = T_DPD + 1;
        else                 len = T_ADV + nd + 1;
        for (int i = 0; i < len; i++) begin
            if (i == len - 1) begin
                chk(rq, "rsp_valid at end", {31'd0, rsp_valid}, 1);
                chk(rq, "rsp_err", {31'd0, rsp_err}, {31'd0, eerr});
                chk(rq, "ce high at end", {30'd0, f_ce_n, r_ce_n}, 3);
                chk(rq, "bus released at end", {31'd0, bus_oe}, 0);
                chk(rq, "ready at end", {31'd0, req_ready}, 0);
                if (!eerr && op < 2'd2 && !wr) chk(rq, "read data", {16'd0, rsp_rdata}, {16'd0, erd});
                if (eerr) chk(rq, "error data", {16'd0, rsp_rdata}, 0);
            end else begin
                chk(rq, "busy", {30'd0, req_ready, rsp_valid}, 0);
                if (op >= 2'd2) begin
                    chk(rq, "power-down ce", {30'd0, f_ce_n, r_ce_n}, 2);
                    chk(rq, "power-down strobes", {29'd0, lat_n, r_oe_n, r_we_n}, 7);
                end else begin
                    chk(rq, "die select", {30'd0, f_ce_n, r_ce_n}, ramish ? 32'd2 : 32'd1);
                    chk(rq, "upper address", {25'd0, addr_hi}, {25'd0, ehi});
                    chk(rq, "lanes", {30'd0, r_ub_n, r_lb_n}, {30'd0, elanes});
                    chk("R7", "register select", {31'd0, r_cre}, {31'd0, cfg});
                    if (i < T_ADV) begin
                        chk("R2", "latch low", {31'd0, lat_n}, 0);
                        chk("R2", "address drive", {15'd0, bus_oe, bus_out}, {15'd0, 1'b1, elo});
                        chk("R2", "no oe/we in address", {28'd0, f_oe_n, f_we_n, r_oe_n, r_we_n}, 32'hF);
                    end else if (wr) begin
                        chk("R4", "latch high", {31'd0, lat_n}, 1);
                        chk("R4", "write drive", {15'd0, bus_oe, bus_out}, {15'd0, 1'b1, wd});
                        chk("R4", "we low", {28'd0, f_oe_n, f_we_n, r_oe_n, r_we_n},
                            ramish ? 32'hE : 32'hB);
                    end else begin
                        chk("R3", "bus released", {31'd0, bus_oe}, 0);
                        chk("R3", "oe low", {28'd0, f_oe_n, f_we_n, r_oe_n, r_we_n},
                            ramish ? 32'hD : 32'h7);
                    end
                end
            end
            @(negedge clk);
        end
        idle_pins(rq);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle_pins("R13");
        chk("R13", "lanes and select", {29'd0, r_ub_n, r_lb_n, r_cre}, 6);
        rst_n = 1'b1;
        @(negedge clk);
        idle_pins("R13");
        // R2 R3 R5: flash read, full upper address.
        dev_word = 16'hBEEF;
        access("R5", 2'd0, 1'b0, 1'b0, 23'h5A1234, 16'h0, 2'b11, 1'b0, 7'h5A, 16'h1234, 16'hBEEF, 2'b11);
        // R4: flash write.
        access("R4", 2'd0, 1'b1, 1'b0, 23'h7F00AA, 16'h1357, 2'b11, 1'b0, 7'h7F, 16'h00AA, 16'h0, 2'b11);
        // R5: RAM write, lines 22:21 forced 0.
        access("R5", 2'd0, 1'b1, 1'b1, 23'h7F4321, 16'h2468, 2'b11, 1'b0, 7'h1F, 16'h4321, 16'h0, 2'b00);
        // R6: lower lane only, upper lane data returned as 0.
        dev_word = 16'hA55A;
        access("R6", 2'd0, 1'b0, 1'b1, 23'h012345, 16'h0, 2'b01, 1'b0, 7'h01, 16'h2345, 16'h005A, 2'b10);
        // R6: no lanes, RAM still selected, data 0.
        access("R6", 2'd0, 1'b0, 1'b1, 23'h000010, 16'h0, 2'b00, 1'b0, 7'h00, 16'h0010, 16'h0000, 2'b11);
        // R7: bus-register read, line 19 high.
        dev_word = 16'h9D1F;
        access("R7", 2'd1, 1'b0, 1'b0, 23'h000001, 16'h0, 2'b11, 1'b0, 7'h08, 16'h0000, 16'h9D1F, 2'b00);
        // R9: entry refused with reset shadow of 1.
        access("R9", 2'd2, 1'b0, 1'b0, 23'h0, 16'h0, 2'b11, 1'b1, 7'h0, 16'h0, 16'h0, 2'b11);
        // R7 R9: write refresh register with bit 4 set, entry still refused.
        access("R7", 2'd1, 1'b1, 1'b0, 23'h000000, 16'h0010, 2'b11, 1'b0, 7'h00, 16'h0010, 16'h0, 2'b00);
        access("R9", 2'd2, 1'b0, 1'b0, 23'h0, 16'h0, 2'b11, 1'b1, 7'h0, 16'h0, 16'h0, 2'b11);
        // R7 R12: device-ID select refused in the narrow variant.
        access("R12", 2'd1, 1'b0, 1'b0, 23'h000002, 16'h0, 2'b11, 1'b1, 7'h0, 16'h0, 16'h0, 2'b11);
        // R11: exit while awake refused.
        access("R11", 2'd3, 1'b0, 1'b0, 23'h0, 16'h0, 2'b11, 1'b1, 7'h0, 16'h0, 16'h0, 2'b11);
        // R9 R10: clear bit 4, then enter power-down.
        access("R9", 2'd1, 1'b1, 1'b0, 23'h000000, 16'h0000, 2'b11, 1'b0, 7'h00, 16'h0000, 16'h0, 2'b00);
        access("R10", 2'd2, 1'b0, 1'b0, 23'h0, 16'h0, 2'b11, 1'b0, 7'h0, 16'h0, 16'h0, 2'b11);
        // R10: RAM read and register access refused, flash still served.
        access("R10", 2'd0, 1'b0, 1'b1, 23'h000100, 16'h0, 2'b11, 1'b1, 7'h0, 16'h0, 16'h0, 2'b11);
        access("R10", 2'd1, 1'b0, 1'b0, 23'h000001, 16'h0, 2'b11, 1'b1, 7'h0, 16'h0, 16'h0, 2'b11);
        dev_word = 16'h0F0F;
        access("R10", 2'd0, 1'b0, 1'b0, 23'h230042, 16'h0, 2'b11, 1'b0, 7'h23, 16'h0042, 16'h0F0F, 2'b11);
        // R11: second entry refused, then exit.
        access("R11", 2'd2, 1'b0, 1'b0, 23'h0, 16'h0, 2'b11, 1'b1, 7'h0, 16'h0, 16'h0, 2'b11);
        access("R11", 2'd3, 1'b0, 1'b0, 23'h0, 16'h0, 2'b11, 1'b0, 7'h0, 16'h0, 16'h0, 2'b11);
        // R11: RAM served again after exit.
        dev_word = 16'hC3C3;
        access("R11", 2'd0, 1'b0, 1'b1, 23'h00ABCD, 16'h0, 2'b10, 1'b0, 7'h00, 16'hABCD, 16'hC300, 2'b01);
        // R1: back-to-back flash write then RAM write.
        access("R1", 2'd0, 1'b1, 1'b0, 23'h400001, 16'h1111, 2'b11, 1'b0, 7'h40, 16'h0001, 16'h0, 2'b11);
        access("R1", 2'd0, 1'b1, 1'b1, 23'h400002, 16'h2222, 2'b11, 1'b0, 7'h00, 16'h0002, 16'h0, 2'b00);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule